// File: doc/BRIEF.md
# Accumulator ALU with per-flag update enables

This block is the combinational arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes an operation code, a register operand, a memory-or-immediate operand and the carry flag currently held in the status register. It returns a result byte with a write strobe, plus new values for the negative (N), overflow (V), zero (Z) and carry (C) flags. Each flag comes with its own update strobe, so the surrounding status register changes only the bits that the operation is meant to touch.

Arithmetic operations share a single adder. Subtraction and compare feed it the inverted memory operand. Subtraction takes the incoming carry as a "no borrow" bit, while compare forces that bit to one. Increment and decrement also go through the adder, with a constant second operand. Shifts and rotates act on the register operand. Bit test and compare produce flags only and write no result. Decimal correction, operand fetch and register storage belong to other blocks.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) gives result = (reg + mem + carry_in) mod 256 with result_we high. C is the carry out of bit 7. V is set when reg and mem have the same sign and the result's sign differs from it. N and Z are also updated, so all four flag enables are high.
- R2: Op code 1 (subtract) gives result = (reg - mem - (1 - carry_in)) mod 256 with result_we high. C is 1 when no borrow occurred, meaning reg >= mem + (1 - carry_in). V is set on signed overflow of that difference. All four flag enables are high.
- R3: Op codes 2, 3 and 4 write reg AND mem, reg OR mem and reg XOR mem. Only the N and Z enables are high.
- R4: Op code 5 shifts reg left, putting 0 into bit 0 and the old bit 7 into C. Op code 6 shifts reg right, putting 0 into bit 7 and the old bit 0 into C. Both write the result and enable N, Z and C.
- R5: Op code 7 rotates reg left, with carry_in entering bit 0 and the old bit 7 going to C. Op code 8 rotates reg right, with carry_in entering bit 7 and the old bit 0 going to C. Both write the result and enable N, Z and C.
- R6: Op code 9 (bit test) sets Z when reg AND mem is zero, copies mem bit 7 into N and mem bit 6 into V, and writes no result. The C enable is low.
- R7: Op code 10 (compare) sets N and Z from reg - mem and sets C when reg >= mem as unsigned numbers. It writes no result, and the V enable is low.
- R8: Op code 11 adds one to reg, so 0xFF becomes 0x00. Op code 12 subtracts one from reg, so 0x00 becomes 0xFF. Both write the result and enable only N and Z.
- R9: Op code 13 (pass) writes mem unchanged as the result and enables only N and Z. Loads and transfers use this code.
- R10: Op codes 14 and 15 raise no write or flag enable.
- R11: Whenever the result is written and N and Z are enabled, N equals result bit 7 and Z is set exactly when the result is zero.
- R12: A flag whose enable is low reads 0. The result reads 0 when result_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| reg_opnd | input | 8 | Register (accumulator or index) operand |
| mem_opnd | input | 8 | Memory or immediate operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Computed value |
| result_we | output | 1 | Result write strobe |
| flag_n | output | 1 | New negative flag |
| flag_n_we | output | 1 | Negative flag update strobe |
| flag_v | output | 1 | New overflow flag |
| flag_v_we | output | 1 | Overflow flag update strobe |
| flag_z | output | 1 | New zero flag |
| flag_z_we | output | 1 | Zero flag update strobe |
| flag_c | output | 1 | New carry flag |
| flag_c_we | output | 1 | Carry flag update strobe |

## Verification
Some properties are checked on every input combination the stimulus produces: the sum-and-carry identity for add, the unsigned ordering behind compare's carry, the bit copies made by bit test, the logic ops' narrow flag subset, the silent reserved codes, and the N/Z relation to any written result. The exact signed overflow for add and subtract, the borrow convention, the directions of shifts and rotates, and the wrap of increment and decrement can only be shown by the bench's reference model. That model is run over every pair of operands, with the op code and carry varying, and over chosen edge cases such as 0x7F+1, 0x80-1 and carry rotating through bit 7.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_ASL  = 4'd5,
      OP_LSR  = 4'd6,
      OP_ROL  = 4'd7,
      OP_ROR  = 4'd8,
      OP_BIT  = 4'd9,
      OP_CMP  = 4'd10,
      OP_INC  = 4'd11,
      OP_DEC  = 4'd12,
      OP_PASS = 4'd13,
      OP_RSV0 = 4'd14,
      OP_RSV1 = 4'd15
   } alu_op_e;

   // which outputs an operation is allowed to update
   typedef struct packed {
      logic res;
      logic n;
      logic v;
      logic z;
      logic c;
   } upd_mask_t;

   // selects inside the logic unit
   localparam logic [1:0] LOG_AND = 2'd0;
   localparam logic [1:0] LOG_OR  = 2'd1;
   localparam logic [1:0] LOG_XOR = 2'd2;

   // selects inside the shift unit
   localparam logic [1:0] SH_ASL = 2'd0;
   localparam logic [1:0] SH_LSR = 2'd1;
   localparam logic [1:0] SH_ROL = 2'd2;
   localparam logic [1:0] SH_ROR = 2'd3;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         inv_b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic [W-1:0] b_eff;

   assign b_eff = inv_b ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = cy[W];
      end else begin : g_infer
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
      end
   endgenerate

   // same-sign addends, result sign flipped
   assign ovf = (a[MSB] == b_eff[MSB]) & (sum[MSB] != a[MSB]);

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   always_comb begin
      unique case (sel)
         LOG_OR:  y = a | b;
         LOG_XOR: y = a ^ b;
         default: y = a & b;
      endcase
   end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   sel,
   input  logic [W-1:0] a,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout
);

   localparam int MSB = W - 1;

   always_comb begin
      unique case (sel)
         SH_ASL: begin
            y    = {a[MSB-1:0], 1'b0};
            cout = a[MSB];
         end
         SH_LSR: begin
            y    = {1'b0, a[MSB:1]};
            cout = a[0];
         end
         SH_ROL: begin
            y    = {a[MSB-1:0], cin};
            cout = a[MSB];
         end
         default: begin
            y    = {cin, a[MSB:1]};
            cout = a[0];
         end
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]   op_sel,
   input  logic [W-1:0] reg_opnd,
   input  logic [W-1:0] mem_opnd,
   input  logic         carry_in,
   output logic [W-1:0] result,
   output logic         result_we,
   output logic         flag_n,
   output logic         flag_n_we,
   output logic         flag_v,
   output logic         flag_v_we,
   output logic         flag_z,
   output logic         flag_z_we,
   output logic         flag_c,
   output logic         flag_c_we
);

   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("acc_alu: W must be at least 2 (bit test reads two top bits)");
      end
   endgenerate

   alu_op_e      op;
   upd_mask_t    mask;
   logic [W-1:0] arith_b;
   logic         arith_inv;
   logic         arith_cin;
   logic [W-1:0] arith_sum;
   logic         arith_cout;
   logic         arith_ovf;
   logic [1:0]   log_sel;
   logic [W-1:0] log_y;
   logic [1:0]   sh_sel;
   logic [W-1:0] sh_y;
   logic         sh_cout;
   logic [W-1:0] value;
   logic         n_raw;
   logic         v_raw;
   logic         c_raw;

   assign op = alu_op_e'(op_sel);

   // operand preparation for the shared adder
   always_comb begin
      arith_b   = mem_opnd;
      arith_inv = 1'b0;
      arith_cin = carry_in;
      unique case (op)
         OP_SUB: arith_inv = 1'b1;
         OP_CMP: begin
            arith_inv = 1'b1;
            arith_cin = 1'b1;
         end
         OP_INC: begin
            arith_b   = '0;
            arith_cin = 1'b1;
         end
         OP_DEC: begin
            arith_b   = '0;
            arith_inv = 1'b1;
            arith_cin = 1'b0;
         end
         default: ;
      endcase
   end

   acc_alu_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
      .a     (reg_opnd),
      .b     (arith_b),
      .inv_b (arith_inv),
      .cin   (arith_cin),
      .sum   (arith_sum),
      .cout  (arith_cout),
      .ovf   (arith_ovf)
   );

   always_comb begin
      unique case (op)
         OP_OR:   log_sel = LOG_OR;
         OP_XOR:  log_sel = LOG_XOR;
         default: log_sel = LOG_AND;
      endcase
   end

   acc_alu_logic #(.W(W)) u_logic (
      .sel (log_sel),
      .a   (reg_opnd),
      .b   (mem_opnd),
      .y   (log_y)
   );

   always_comb begin
      unique case (op)
         OP_LSR:  sh_sel = SH_LSR;
         OP_ROL:  sh_sel = SH_ROL;
         OP_ROR:  sh_sel = SH_ROR;
         default: sh_sel = SH_ASL;
      endcase
   end

   acc_alu_shift #(.W(W)) u_shift (
      .sel  (sh_sel),
      .a    (reg_opnd),
      .cin  (carry_in),
      .y    (sh_y),
      .cout (sh_cout)
   );

   // value select and update mask per operation
   always_comb begin
      value = '0;
      mask  = '0;
      c_raw = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            value = arith_sum;
            c_raw = arith_cout;
            mask  = '{res: 1'b1, n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
         end
         OP_AND, OP_OR, OP_XOR: begin
            value = log_y;
            mask  = '{res: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         end
         OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
            value = sh_y;
            c_raw = sh_cout;
            mask  = '{res: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         end
         OP_BIT: begin
            value = log_y;
            mask  = '{res: 1'b0, n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
         end
         OP_CMP: begin
            value = arith_sum;
            c_raw = arith_cout;
            mask  = '{res: 1'b0, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         end
         OP_INC, OP_DEC: begin
            value = arith_sum;
            mask  = '{res: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         end
         OP_PASS: begin
            value = mem_opnd;
            mask  = '{res: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
         end
         default: ;
      endcase
   end

   // bit test takes N and V straight from the memory operand
   assign n_raw = (op == OP_BIT) ? mem_opnd[MSB]   : value[MSB];
   assign v_raw = (op == OP_BIT) ? mem_opnd[MSB-1] : arith_ovf;

   assign result    = mask.res ? value : '0;
   assign result_we = mask.res;
   assign flag_n    = mask.n & n_raw;
   assign flag_n_we = mask.n;
   assign flag_v    = mask.v & v_raw;
   assign flag_v_we = mask.v;
   assign flag_z    = mask.z & (value == '0);
   assign flag_z_we = mask.z;
   assign flag_c    = mask.c & c_raw;
   assign flag_c_we = mask.c;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int W = 8
) (
   input logic [3:0]   op_sel,
   input logic [W-1:0] reg_opnd,
   input logic [W-1:0] mem_opnd,
   input logic         carry_in,
   input logic [W-1:0] result,
   input logic         result_we,
   input logic         flag_n,
   input logic         flag_n_we,
   input logic         flag_v,
   input logic         flag_v_we,
   input logic         flag_z,
   input logic         flag_z_we,
   input logic         flag_c,
   input logic         flag_c_we
);

   logic [W:0] add_ref;

   assign add_ref = {1'b0, reg_opnd} + {1'b0, mem_opnd} + {{W{1'b0}}, carry_in};

   always_comb begin
      if (!$isunknown(op_sel)) begin
         // R1
         add_sum_chk: assert (op_sel != 4'd0 || {flag_c, result} == add_ref);
         // R3
         logic_subset_chk: assert (!(op_sel inside {4'd2, 4'd3, 4'd4}) ||
                                   (result_we && flag_n_we && flag_z_we && !flag_v_we && !flag_c_we));
         // R6
         bit_copy_chk: assert (op_sel != 4'd9 ||
                               (!result_we && flag_n == mem_opnd[W-1] && flag_v == mem_opnd[W-2] &&
                                flag_z == ((reg_opnd & mem_opnd) == '0)));
         // R7
         cmp_order_chk: assert (op_sel != 4'd10 ||
                                (!result_we && !flag_v_we && flag_c == (reg_opnd >= mem_opnd)));
         // R10
         reserved_quiet_chk: assert (op_sel < 4'd14 ||
                                     !(result_we | flag_n_we | flag_v_we | flag_z_we | flag_c_we));
         // R11
         nz_track_chk: assert (!(result_we && flag_n_we && flag_z_we) ||
                               (flag_n == result[W-1] && flag_z == (result == '0)));
         // R12
         masked_zero_chk: assert ((result_we || result == '0) && (flag_v_we || !flag_v) &&
                                  (flag_c_we || !flag_c));
      end
   end

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
   .op_sel    (op_sel),
   .reg_opnd  (reg_opnd),
   .mem_opnd  (mem_opnd),
   .carry_in  (carry_in),
   .result    (result),
   .result_we (result_we),
   .flag_n    (flag_n),
   .flag_n_we (flag_n_we),
   .flag_v    (flag_v),
   .flag_v_we (flag_v_we),
   .flag_z    (flag_z),
   .flag_z_we (flag_z_we),
   .flag_c    (flag_c),
   .flag_c_we (flag_c_we)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

   logic       clk = 1'b0;
   logic [3:0] op_sel;
   logic [7:0] reg_opnd;
   logic [7:0] mem_opnd;
   logic       carry_in;
   logic [7:0] result;
   logic       result_we;
   logic       flag_n, flag_n_we, flag_v, flag_v_we;
   logic       flag_z, flag_z_we, flag_c, flag_c_we;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [16:0] vec;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   always #5 clk = ~clk;

   acc_alu uut (
      .op_sel    (op_sel),
      .reg_opnd  (reg_opnd),
      .mem_opnd  (mem_opnd),
      .carry_in  (carry_in),
      .result    (result),
      .result_we (result_we),
      .flag_n    (flag_n),
      .flag_n_we (flag_n_we),
      .flag_v    (flag_v),
      .flag_v_we (flag_v_we),
      .flag_z    (flag_z),
      .flag_z_we (flag_z_we),
      .flag_c    (flag_c),
      .flag_c_we (flag_c_we)
   );

   function automatic int sgn(input logic [7:0] x);
      return (x > 8'd127) ? int'(x) - 256 : int'(x);
   endfunction

   // reference model: {result, we, n, n_we, v, v_we, z, z_we, c, c_we}
   function automatic exp_t model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [7:0] b, input logic ci);
      exp_t e;
      int   s, sv;
      logic [7:0] r = 8'h00;
      logic we = 0, n = 0, nw = 0, v = 0, vw = 0, z = 0, zw = 0, c = 0, cw = 0;
      logic [7:0] nz_src = 8'h00;
      case (op)
         4'd0: begin // R1
            s  = int'(a) + int'(b) + int'(ci);
            sv = sgn(a) + sgn(b) + int'(ci);
            r = s[7:0]; we = 1; c = (s > 255); cw = 1; v = (sv > 127 || sv < -128); vw = 1;
            e.tag = "R1";
         end
         4'd1: begin // R2
            s  = int'(a) - int'(b) - (1 - int'(ci));
            sv = sgn(a) - sgn(b) - (1 - int'(ci));
            r = s[7:0]; we = 1; c = (s >= 0); cw = 1; v = (sv > 127 || sv < -128); vw = 1;
            e.tag = "R2";
         end
         4'd2: begin r = a & b; we = 1; e.tag = "R3"; end
         4'd3: begin r = a | b; we = 1; e.tag = "R3"; end
         4'd4: begin r = a ^ b; we = 1; e.tag = "R3"; end
         4'd5: begin r = 8'((int'(a) * 2) % 256); c = (a >= 8'd128); cw = 1; we = 1; e.tag = "R4"; end
         4'd6: begin r = 8'(int'(a) / 2); c = (a % 2 == 1); cw = 1; we = 1; e.tag = "R4"; end
         4'd7: begin r = 8'((int'(a) * 2 + int'(ci)) % 256); c = (a >= 8'd128); cw = 1; we = 1; e.tag = "R5"; end
         4'd8: begin r = 8'(int'(a) / 2 + 128 * int'(ci)); c = (a % 2 == 1); cw = 1; we = 1; e.tag = "R5"; end
         4'd9: begin
            e.tag = "R6 R12";
         end
         4'd10: begin
            nz_src = 8'((int'(a) - int'(b) + 256) % 256);
            c = (a >= b); cw = 1; e.tag = "R7 R12";
         end
         4'd11: begin r = 8'((int'(a) + 1) % 256); we = 1; e.tag = "R8"; end
         4'd12: begin r = 8'((int'(a) + 255) % 256); we = 1; e.tag = "R8"; end
         4'd13: begin r = b; we = 1; e.tag = "R9"; end
         default: e.tag = "R10 R12";
      endcase
      if (op <= 4'd13) begin
         nw = 1; zw = 1;
         if (we) nz_src = r;
         n = nz_src[7];
         z = (nz_src == 8'h00);
      end
      if (op == 4'd9) begin
         n = b[7]; v = b[6]; vw = 1; z = ((a & b) == 8'h00);
      end
      e.vec = {r, we, n, nw, v, vw, z, zw, c, cw};
      return e;
   endfunction

   task automatic drive(input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic ci);
      @(posedge clk);
      #1;
      op_sel   = op;
      reg_opnd = a;
      mem_opnd = b;
      carry_in = ci;
      sb_q.push_back(model(op, a, b, ci));
   endtask

   // monitor: compares half a period after each drive
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() != 0) begin
            exp_t e;
            logic [16:0] act;
            e   = sb_q.pop_front();
            act = {result, result_we, flag_n, flag_n_we, flag_v, flag_v_we,
                   flag_z, flag_z_we, flag_c, flag_c_we};
            checks++;
            if (act !== e.vec) begin
               errors++;
               $display("FAIL %s: op=%0d reg=%h mem=%h c=%b actual=%h expected=%h",
                        e.tag, op_sel, reg_opnd, mem_opnd, carry_in, act, e.vec);
            end
            // R11: N and Z follow any written result
            if (result_we && flag_n_we && flag_z_we) begin
               checks++;
               if (flag_n !== result[7] || flag_z !== (result == 8'h00)) begin
                  errors++;
                  $display("FAIL R11: result=%h actual nz=%b%b expected nz=%b%b",
                           result, flag_n, flag_z, result[7], (result == 8'h00));
               end
            end
         end
      end
   end

   initial begin
      op_sel = 4'd14; reg_opnd = 8'h00; mem_opnd = 8'h00; carry_in = 1'b0;
      // idle state: reserved code, all enables low (R10)
      drive(4'd14, 8'h00, 8'h00, 1'b0);
      drive(4'd15, 8'hFF, 8'hFF, 1'b1);
      // R1 signed overflow and carry wrap
      drive(4'd0, 8'h7F, 8'h01, 1'b0);
      drive(4'd0, 8'hFF, 8'h01, 1'b0);
      drive(4'd0, 8'h80, 8'h80, 1'b1);
      // R2 overflow, borrow in, no borrow
      drive(4'd1, 8'h80, 8'h01, 1'b1);
      drive(4'd1, 8'h00, 8'h00, 1'b0);
      drive(4'd1, 8'h05, 8'h05, 1'b1);
      // R3 logic ops
      drive(4'd2, 8'hF0, 8'h0F, 1'b1);
      drive(4'd4, 8'hA5, 8'h5A, 1'b0);
      // R4 shifts, R5 rotates through carry
      drive(4'd5, 8'h81, 8'h00, 1'b1);
      drive(4'd6, 8'h01, 8'h00, 1'b1);
      drive(4'd7, 8'h80, 8'h00, 1'b1);
      drive(4'd8, 8'h01, 8'h00, 1'b1);
      // R6 bit test: zero AND, operand bits copied
      drive(4'd9, 8'h3F, 8'hC0, 1'b0);
      drive(4'd9, 8'h01, 8'h41, 1'b1);
      // R7 compare equal, less, greater
      drive(4'd10, 8'h42, 8'h42, 1'b0);
      drive(4'd10, 8'h10, 8'h20, 1'b1);
      drive(4'd10, 8'hF0, 8'h01, 1'b0);
      // R8 wrap both ways
      drive(4'd11, 8'hFF, 8'h00, 1'b0);
      drive(4'd12, 8'h00, 8'h00, 1'b1);
      // R9 pass of a zero and a negative value
      drive(4'd13, 8'hAA, 8'h00, 1'b0);
      drive(4'd13, 8'h00, 8'h80, 1'b0);
      // sweep: every operand pair, op code and carry varying
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            drive(4'((3 * a + b) % 16), 8'(a), 8'(b), 1'(((a >> 1) ^ b) & 1));
         end
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule